// File: doc/BRIEF.md
# Mask-destination vector compare unit

This block applies one element-wise operation to a window of vector elements and collects one result bit per element into a destination mask register. A start pulse captures the configuration: operation select, masking variant, scalar-or-vector choice for the second operand, the unmasked flag, the window bounds and a pending-exception flag. The block then walks the element indices from the window start up to the last active element, one per cycle. At each step it presents the index on `elem_idx`, reads the two operand elements that the surrounding logic returns for that index, and updates the matching destination bit.

Two masking variants exist. In the *write-all* variant, every element in the window gets a fresh result bit, and the effective mask bit goes into the operation as a carry input. In the *skip* variant, an element whose mask is in force and clear keeps its old destination bit. If an exception was already pending at start, nothing is written. On normal completion the block pulses a request to zero the start index.

Top module: `vmask_cmp_unit`

## Requirements
- R1: The destination and source mask bit for element i is bit i of the flat vector, which is bit i&7 of byte i>>3. Updating element i changes only `dest_out[i]`.
- R2: Only elements with vstart <= i < min(vl, MAX_VL) are written. Every other destination bit keeps the value loaded from `dest_in` at start.
- R3: When `scalar_sel` is 1, `scalar_val` is the second operand for every element. When it is 0, `vs1_data` for the current index is used.
- R4: The operation codes are 0 = equal, 1 = not equal, 2 = unsigned vs2 < vs1, and 3 = carry-out of vs2 + vs1 + carry_in computed at ELEN bits.
- R5: The effective mask bit is (not `vm`) AND `mask_in[i]`. It is the carry_in of every element in both variants.
- R6: With `set_mode` = 1, every element in the window is written with the operation result, whatever its mask bit.
- R7: With `set_mode` = 0, an element with `vm` = 0 and `mask_in[i]` = 0 keeps its old bit. All other in-window elements are written.
- R8: If `exc_pending` is 1 at start, `dest_out` equals `dest_in` when `done` pulses, and `vstart_clr` stays low. After a normal completion `vstart_clr` pulses together with `done`.
- R9: `done` is high for exactly one cycle. It appears N cycles after the start edge, where N is the number of elements in the window, or 0 for an empty window or a pending exception. `busy` is high from the cycle after the start edge through the `done` cycle.
- R10: A start pulse while `busy` is high, including the `done` cycle, is ignored. It causes no further `done` and no change to the captured configuration.
- R11: After reset, `busy`, `done` and `vstart_clr` are low and `dest_out` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Single-cycle request to begin; accepted only while idle |
| op_sel | input | 2 | Operation code (R4) |
| set_mode | input | 1 | 1 = write-all variant, 0 = skip variant |
| scalar_sel | input | 1 | 1 = second operand is `scalar_val` |
| vm | input | 1 | 1 = unmasked operation |
| vstart | input | LW | First element index |
| vl | input | LW | Active length (clamped to MAX_VL) |
| exc_pending | input | 1 | Exception already pending at start |
| mask_in | input | MAX_VL | Source mask register, flat bit i = element i |
| dest_in | input | MAX_VL | Old contents of the destination mask register |
| scalar_val | input | ELEN | Scalar second operand |
| vs2_data | input | ELEN | vs2 element at `elem_idx` |
| vs1_data | input | ELEN | vs1 element at `elem_idx` |
| elem_idx | output | IW | Index of the element being processed |
| elem_valid | output | 1 | An element is being processed this cycle |
| dest_out | output | MAX_VL | Updated destination mask register |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| vstart_clr | output | 1 | Request to zero the start index, on normal completion |

## Verification
The completion cycle is where two functions meet: `done` and `vstart_clr` are presented while the sequencer is in its final state, and a new start pulse can arrive in that same cycle. The bench provokes this by pulsing `start` exactly in the `done` cycle, with a different operation code and destination image on the inputs. The result is judged correct if the scoreboard sees the original operation's result and no second `done`, and if `busy` is low in the following cycle. The skip and write-all variants are run on the same mask pattern with the carry operation, so that the mask's two roles (write gate and carry input) are told apart.

// File: rtl/vmcmp_pkg.sv
package vmcmp_pkg;

  typedef enum logic [1:0] {
    OP_EQ    = 2'd0,
    OP_NE    = 2'd1,
    OP_LTU   = 2'd2,
    OP_CARRY = 2'd3
  } cmp_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } seq_state_e;

endpackage

// File: rtl/vmcmp_rst_sync.sv
module vmcmp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_sync_n = hold_q;
endmodule

// File: rtl/vmcmp_elem_op.sv
module vmcmp_elem_op
  import vmcmp_pkg::*;
#(
  parameter int ELEN = 8
) (
  input  cmp_op_e           op,
  input  logic [ELEN-1:0]   opa,
  input  logic [ELEN-1:0]   opb,
  input  logic              cin,
  output logic              res
);
  localparam int SW = ELEN + 1;

  logic [SW-1:0] sum;

  always_comb begin
    sum = {1'b0, opa} + {1'b0, opb} + SW'(cin);
    unique case (op)
      OP_EQ:    res = (opa == opb);
      OP_NE:    res = (opa != opb);
      OP_LTU:   res = (opa < opb);
      OP_CARRY: res = sum[SW-1];
      default:  res = 1'b0;
    endcase
  end
endmodule

// File: rtl/vmcmp_mask_reg.sv
module vmcmp_mask_reg #(
  parameter int W = 32,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [W-1:0]  load_val,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic          wr_bit,
  output logic [W-1:0]  q
);
  logic [W-1:0] bit_d;
  logic [W-1:0] bit_en;

  for (genvar g = 0; g < W; g++) begin : g_bit
    always_comb begin
      bit_en[g] = load | (wr_en && (wr_idx == IW'(g)));
      bit_d[g]  = load ? load_val[g] : wr_bit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q[g] <= 1'b0;
      end else if (bit_en[g]) begin
        q[g] <= bit_d[g];
      end
    end
  end

  // A single-element write must leave every other bit alone
  AST_ONE_BIT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !load) |=> ($countones(q ^ $past(q)) <= 1)); // R1
endmodule

// File: rtl/vmcmp_seq.sv
module vmcmp_seq
  import vmcmp_pkg::*;
#(
  parameter int MAX_VL = 32,
  localparam int LW = $clog2(MAX_VL + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          exc,
  input  logic [LW-1:0] vstart,
  input  logic [LW-1:0] vl,
  output logic          accept,
  output logic          busy,
  output logic          done,
  output logic          clr,
  output logic          elem_valid,
  output logic [LW-1:0] idx
);
  localparam logic [LW-1:0] VL_CAP = LW'(MAX_VL);

  seq_state_e    state_q, state_d;
  logic [LW-1:0] idx_q, idx_d;
  logic [LW-1:0] last_q, last_d;
  logic [LW-1:0] first_q, first_d;
  logic          exc_q, exc_d;
  logic [LW-1:0] vl_eff;
  logic          empty;

  always_comb begin
    vl_eff = (vl > VL_CAP) ? VL_CAP : vl;
    empty  = (vstart >= vl_eff);
    accept = start && (state_q == ST_IDLE);
  end

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    last_d  = last_q;
    first_d = first_q;
    exc_d   = exc_q;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          exc_d   = exc;
          idx_d   = vstart;
          first_d = vstart;
          last_d  = vl_eff - LW'(1);
          state_d = (exc || empty) ? ST_FIN : ST_RUN;
        end
      end
      ST_RUN: begin
        if (idx_q == last_q) begin
          state_d = ST_FIN;
        end else begin
          idx_d = idx_q + LW'(1);
        end
      end
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      last_q  <= '0;
      first_q <= '0;
      exc_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      last_q  <= last_d;
      first_q <= first_d;
      exc_q   <= exc_d;
    end
  end

  always_comb begin
    busy       = (state_q != ST_IDLE);
    done       = (state_q == ST_FIN);
    clr        = (state_q == ST_FIN) && !exc_q;
    elem_valid = (state_q == ST_RUN);
    idx        = idx_q;
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9

  AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start)); // R9

  AST_EXC_NO_ELEMENTS: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && exc) |=> (done && !elem_valid && !clr)); // R8

  AST_IDX_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    elem_valid |-> ((idx_q >= first_q) && (idx_q < VL_CAP) && (idx_q <= last_q))); // R2

  AST_FIN_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy); // R10
endmodule

// File: rtl/vmask_cmp_unit.sv
module vmask_cmp_unit
  import vmcmp_pkg::*;
#(
  parameter int ELEN   = 8,
  parameter int MAX_VL = 32,
  localparam int LW = $clog2(MAX_VL + 1),
  localparam int IW = (MAX_VL > 1) ? $clog2(MAX_VL) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        op_sel,
  input  logic              set_mode,
  input  logic              scalar_sel,
  input  logic              vm,
  input  logic [LW-1:0]     vstart,
  input  logic [LW-1:0]     vl,
  input  logic              exc_pending,
  input  logic [MAX_VL-1:0] mask_in,
  input  logic [MAX_VL-1:0] dest_in,
  input  logic [ELEN-1:0]   scalar_val,
  input  logic [ELEN-1:0]   vs2_data,
  input  logic [ELEN-1:0]   vs1_data,
  output logic [IW-1:0]     elem_idx,
  output logic              elem_valid,
  output logic [MAX_VL-1:0] dest_out,
  output logic              busy,
  output logic              done,
  output logic              vstart_clr
);
  logic              rst_sync_n;
  logic              accept;
  logic [LW-1:0]     seq_idx;

  cmp_op_e           op_q;
  logic              set_q, scal_q, vm_q;
  logic [MAX_VL-1:0] mask_q;
  logic [ELEN-1:0]   scalar_q;

  logic              mask_bit;
  logic              eff_mask;
  logic              wr_en;
  logic              res_bit;
  logic [ELEN-1:0]   opb;

  vmcmp_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  vmcmp_seq #(.MAX_VL(MAX_VL)) u_seq (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .start      (start),
    .exc        (exc_pending),
    .vstart     (vstart),
    .vl         (vl),
    .accept     (accept),
    .busy       (busy),
    .done       (done),
    .clr        (vstart_clr),
    .elem_valid (elem_valid),
    .idx        (seq_idx)
  );

  // Configuration captured on an accepted start
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      op_q     <= OP_EQ;
      set_q    <= 1'b0;
      scal_q   <= 1'b0;
      vm_q     <= 1'b0;
      mask_q   <= '0;
      scalar_q <= '0;
    end else if (accept) begin
      op_q     <= cmp_op_e'(op_sel);
      set_q    <= set_mode;
      scal_q   <= scalar_sel;
      vm_q     <= vm;
      mask_q   <= mask_in;
      scalar_q <= scalar_val;
    end
  end

  always_comb begin
    elem_idx = seq_idx[IW-1:0];
    mask_bit = mask_q[elem_idx];
    eff_mask = !vm_q && mask_bit;
    wr_en    = elem_valid && (set_q || vm_q || mask_bit);
    opb      = scal_q ? scalar_q : vs1_data;
  end

  vmcmp_elem_op #(.ELEN(ELEN)) u_op (
    .op  (op_q),
    .opa (vs2_data),
    .opb (opb),
    .cin (eff_mask),
    .res (res_bit)
  );

  vmcmp_mask_reg #(.W(MAX_VL)) u_dst (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (accept),
    .load_val (dest_in),
    .wr_en    (wr_en),
    .wr_idx   (elem_idx),
    .wr_bit   (res_bit),
    .q        (dest_out)
  );

  AST_SKIP_KEEPS_BIT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (elem_valid && !set_q && !vm_q && !mask_bit)
      |=> (dest_out[$past(elem_idx)] == $past(dest_out[elem_idx]))); // R7

  AST_IDLE_HOLDS_DEST: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!busy && !start) |=> $stable(dest_out)); // R2

  AST_CONFIG_FROZEN: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (busy && $past(busy)) |-> ($stable(op_q) && $stable(mask_q))); // R10
endmodule

// File: tb/vmask_cmp_unit_tb_top.sv
`timescale 1ns/1ps
module vmask_cmp_unit_tb_top;
  localparam int ELEN   = 8;
  localparam int MAX_VL = 32;
  localparam int LW = $clog2(MAX_VL + 1);
  localparam int IW = $clog2(MAX_VL);

  logic              clk = 1'b0;
  logic              rst_n;
  logic              start;
  logic [1:0]        op_sel;
  logic              set_mode, scalar_sel, vm, exc_pending;
  logic [LW-1:0]     vstart, vl;
  logic [MAX_VL-1:0] mask_in, dest_in;
  logic [ELEN-1:0]   scalar_val, vs2_data, vs1_data;
  logic [IW-1:0]     elem_idx;
  logic              elem_valid;
  logic [MAX_VL-1:0] dest_out;
  logic              busy, done, vstart_clr;

  logic [ELEN-1:0] vs2_arr [MAX_VL];
  logic [ELEN-1:0] vs1_arr [MAX_VL];

  assign vs2_data = vs2_arr[elem_idx];
  assign vs1_data = vs1_arr[elem_idx];

  always #5 clk = ~clk;

  vmask_cmp_unit #(.ELEN(ELEN), .MAX_VL(MAX_VL)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel),
    .set_mode(set_mode), .scalar_sel(scalar_sel), .vm(vm),
    .vstart(vstart), .vl(vl), .exc_pending(exc_pending),
    .mask_in(mask_in), .dest_in(dest_in), .scalar_val(scalar_val),
    .vs2_data(vs2_data), .vs1_data(vs1_data), .elem_idx(elem_idx),
    .elem_valid(elem_valid), .dest_out(dest_out), .busy(busy),
    .done(done), .vstart_clr(vstart_clr)
  );

  typedef struct {
    logic [MAX_VL-1:0] dest;
    logic              clr;
    int                lat;
    int                s_cyc;
    string             tag;
  } exp_item_t;

  exp_item_t sb_q[$];
  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // Monitor: pops one expected item per done pulse
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R10", "unexpected done", 64'd1, 64'd0);
      end else begin
        exp_item_t it;
        it = sb_q.pop_front();
        check(dest_out == it.dest, it.tag, "dest", 64'(dest_out), 64'(it.dest));
        check(vstart_clr == it.clr, "R8", "vstart_clr", 64'(vstart_clr), 64'(it.clr));
        check((cyc - it.s_cyc) == it.lat, "R9", "latency",
              64'(cyc - it.s_cyc), 64'(it.lat));
      end
    end
  end

  function automatic logic elem_res(input int op, input logic [ELEN-1:0] a,
                                    input logic [ELEN-1:0] b, input logic c);
    int s;
    s = int'(a) + int'(b) + int'(c);
    case (op)
      0: return a == b;
      1: return a != b;
      2: return a < b;
      default: return s >= (1 << ELEN);
    endcase
  endfunction

  task automatic run_op(input string tag, input int op, input bit setm,
                        input bit scal, input bit vmb, input int vs, input int vlen,
                        input bit exc, input logic [MAX_VL-1:0] msk,
                        input logic [MAX_VL-1:0] d0, input logic [ELEN-1:0] sv,
                        input bit poke);
    exp_item_t it;
    int vle;
    int n;
    vle = (vlen > MAX_VL) ? MAX_VL : vlen;
    it.dest = d0;
    for (int i = 0; i < MAX_VL; i++) begin
      if (!exc && i >= vs && i < vle) begin
        logic em;
        em = !vmb && msk[i];
        if (setm || vmb || msk[i])
          it.dest[i] = elem_res(op, vs2_arr[i], scal ? sv : vs1_arr[i], em);
      end
    end
    n = (exc || vs >= vle) ? 0 : (vle - vs);
    it.lat = n;
    it.clr = !exc;
    it.tag = tag;
    @(negedge clk);
    op_sel = 2'(op); set_mode = setm; scalar_sel = scal; vm = vmb;
    vstart = LW'(vs); vl = LW'(vlen); exc_pending = exc;
    mask_in = msk; dest_in = d0; scalar_val = sv;
    start = 1'b1;
    it.s_cyc = cyc + 1;
    sb_q.push_back(it);
    @(negedge clk);
    start = 1'b0;
    if (poke && n > 1) begin
      start = 1'b1; op_sel = ~op_sel; dest_in = ~d0;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    if (poke) begin
      // start pulse in the done cycle, must be ignored
      start = 1'b1; op_sel = ~op_sel; dest_in = ~d0;
      @(negedge clk);
      start = 1'b0;
      check(busy == 1'b0, "R10", "busy after ignored start", 64'(busy), 64'd0);
    end
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; op_sel = 2'd0; set_mode = 1'b0;
    scalar_sel = 1'b0; vm = 1'b1; vstart = '0; vl = '0; exc_pending = 1'b0;
    mask_in = '0; dest_in = '0; scalar_val = '0;
    for (int i = 0; i < MAX_VL; i++) begin
      vs2_arr[i] = ELEN'(i * 37 + 11);
      vs1_arr[i] = (i % 3 == 0) ? ELEN'(i * 37 + 11) : ELEN'(i * 53 + 7);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R11: reset state
    check(busy == 1'b0, "R11", "busy", 64'(busy), 64'd0);
    check(done == 1'b0, "R11", "done", 64'(done), 64'd0);
    check(vstart_clr == 1'b0, "R11", "vstart_clr", 64'(vstart_clr), 64'd0);
    check(dest_out == '0, "R11", "dest_out", 64'(dest_out), 64'd0);

    // R4 equal, unmasked, full length; R1 bit placement
    run_op("R4", 0, 1'b1, 1'b0, 1'b1, 0, 32, 1'b0, '0, 32'hA5A5_5A5A, 8'h00, 1'b0);
    // R4 not-equal; R2 window inside the register
    run_op("R2", 1, 1'b0, 1'b0, 1'b1, 5, 20, 1'b0, '0, 32'hFFFF_0000, 8'h00, 1'b0);
    // R4 unsigned less-than against a scalar; R3
    run_op("R3", 2, 1'b1, 1'b1, 1'b1, 0, 32, 1'b0, '0, 32'h0, 8'h80, 1'b0);
    // R4 equal against a scalar, skip variant with mask; R7
    vs2_arr[3] = 8'h42; vs2_arr[4] = 8'h42;
    run_op("R7", 0, 1'b0, 1'b1, 1'b0, 0, 32, 1'b0, 32'h0F0F_3C3C, 32'h5555_AAAA, 8'h42, 1'b0);
    // carry edge values
    for (int i = 0; i < MAX_VL; i++) begin
      vs2_arr[i] = (i % 2 == 0) ? 8'hFF : 8'h7F;
      vs1_arr[i] = (i % 4 < 2) ? 8'h00 : 8'h80;
    end
    // R5/R6: carry-out with mask as carry-in, write-all variant
    run_op("R6", 3, 1'b1, 1'b0, 1'b0, 0, 32, 1'b0, 32'h3333_CCCC, 32'hFFFF_FFFF, 8'h00, 1'b0);
    // R5 carry-out, skip variant, same mask
    run_op("R5", 3, 1'b0, 1'b0, 1'b0, 2, 30, 1'b0, 32'h3333_CCCC, 32'hFFFF_FFFF, 8'h00, 1'b0);
    // R5 unmasked: carry_in forced 0 even where mask set
    run_op("R5", 3, 1'b1, 1'b0, 1'b1, 0, 32, 1'b0, 32'hFFFF_FFFF, 32'h0, 8'h00, 1'b0);
    // R8: exception pending, nothing written
    run_op("R8", 1, 1'b1, 1'b0, 1'b1, 0, 32, 1'b1, '0, 32'h1234_5678, 8'h00, 1'b0);
    // R2: empty window
    run_op("R2", 1, 1'b1, 1'b0, 1'b1, 10, 10, 1'b0, '0, 32'h8765_4321, 8'h00, 1'b0);
    // R2: length above the register clamps; single-element window R1
    run_op("R2", 0, 1'b1, 1'b0, 1'b1, 28, 40, 1'b0, '0, 32'h0, 8'h00, 1'b0);
    run_op("R1", 1, 1'b1, 1'b0, 1'b1, 31, 32, 1'b0, '0, 32'h0, 8'h00, 1'b0);
    // R10: starts while busy and in the done cycle are ignored
    run_op("R10", 2, 1'b1, 1'b0, 1'b1, 0, 12, 1'b0, '0, 32'hF0F0_F0F0, 8'h00, 1'b1);
    repeat (3) @(negedge clk);
    check(sb_q.size() == 0, "R9", "pending items", 64'(sb_q.size()), 64'd0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule